// File: doc/BRIEF.md
# SPI Frame Integrity Checker

This block is the slave side of a register-mapped serial link that carries fixed 24-bit frames. Chip select, serial clock and data in are brought into the system clock domain through synchronisers. While chip select is low, the block counts serial clock edges and shifts in the data bits. When chip select rises, it judges the frame in three ways: the edge count, the check byte, and how long the link was idle before the frame began. A frame that passes the count and check-byte tests is handed to a register-access port as a single-cycle request. A frame that fails either test is thrown away.

The reply to a request is shifted out on the data-out line during the next frame. After a discarded frame, or after reset, the reply is a fixed default word. Any error sets a sticky fault flag. While the flag is set, an active-low interrupt line is held low. Only an accepted write of a dedicated clear bit removes the flag.

Top module: `spi_frame_guard`

## Requirements
- R1: A frame holds 24 bits and is sent MSB first, sampled on the serial clock rising edge. Bit 23 is the write flag, bits 22:16 are the address, bits 15:8 are the data, and bits 7:0 are a CRC-8 over bits 23:8. The CRC uses polynomial 0x2F, starts at 0xFF and is processed MSB first.
- R2: At the chip-select rising edge, the count of serial clock rising edges seen while chip select was low must be a nonzero multiple of 24. Otherwise the frame is rejected. When more than 24 bits arrive, the last 24 form the frame.
- R3: A frame whose received CRC byte differs from the CRC computed over its first 16 bits is rejected.
- R4: Chip select may fall fewer than GAP_CYCLES clock cycles after the previous chip-select rise. Such a frame sets the fault, but it is still accepted if its count and CRC are good. The first frame after reset is never flagged this way.
- R5: A rejected frame produces no pulse on regValid, so no register is written.
- R6: An accepted frame produces exactly one single-cycle regValid pulse, with regWrite, regAddr and regWdata taken from the frame. regRdata is sampled in that same cycle.
- R7: The 24 bits on miso during a frame answer the previous accepted frame. The reply has the fault status in bit 23, zeros in bits 22:16, the addressed register's contents before any write in bits 15:8, and a CRC-8 over bits 23:8 in bits 7:0. miso changes after serial clock falling edges, and its first bit is valid after chip select falls.
- R8: The reply after a rejected frame, and the first reply after reset, is 0x3C0000.
- R9: Any count, CRC or gap error sets a sticky fault flag, and intN is low while the flag is set.
- R10: The fault clears only on an accepted write to address 0x7F with data bit 0 set. If that same frame has an error, the fault stays set. A write to 0x7F with bit 0 clear leaves the fault unchanged.
- R11: After reset, intN is high, regValid is low and miso is low. miso stays low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csbN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| intN | output | 1 | Active-low fault interrupt |
| regValid | output | 1 | One-cycle register access request |
| regWrite | output | 1 | Request is a write |
| regAddr | output | 7 | Register address |
| regWdata | output | 8 | Write data |
| regRdata | input | 8 | Read data for regAddr, sampled with regValid |

## Verification
The bench sends frames of 0, 23, 25 and 48 bits. A wrong modulo count would either accept a short frame or reject a double-length one. It flips each of the 24 bits of a write frame in turn; a CRC checker that skips part of the frame would let the corrupt write reach the register port. Idle gaps are set well below and well above the limit, and clears are sent with bit 0 low or inside a too-early frame. A wrong flag priority would show as intN rising when it should stay low. Every reply is compared against the previous frame, so an off-by-one-frame lag or a missing default word after a rejected frame shows up at once.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int CRC_W      = 8;
  localparam int HEAD_W     = 1 + ADDR_W;
  localparam int BODY_W     = HEAD_W + DATA_W;
  localparam int FRAME_BITS = BODY_W + CRC_W;

  localparam logic [CRC_W-1:0]      CRC_POLY     = 8'h2F;
  localparam logic [CRC_W-1:0]      CRC_SEED     = 8'hFF;
  localparam logic [ADDR_W-1:0]     CLEAR_ADDR   = 7'h7F;
  localparam logic [FRAME_BITS-1:0] REJECT_REPLY = 24'h3C_0000;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic startFrame;   // chip select fell
    logic takeBit;      // sample data in
    logic nextBit;      // advance data out
    logic closeFrame;   // chip select rose
    logic acceptFrame;  // frame passed count and CRC tests
  } strobe_t;

  function automatic logic [CRC_W-1:0] crcCalc(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = CRC_SEED;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ body[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction
endpackage

// File: rtl/sfg_sync.sv
module sfg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] feed;
    if (g == 0) begin : g_first
      assign feed = din;
    end else begin : g_next
      assign feed = chain[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[g] <= RST_VAL;
      else       chain[g] <= feed;
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
#(
  parameter int GAP_CYCLES = 4750
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csbS,
  input  logic    sclkS,
  input  logic    crcOk,
  input  logic    clearHit,
  output strobe_t st,
  output logic    errNext,
  output logic    regValid,
  output logic    intN
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_CYCLES);

  logic csbPrev, sclkPrev;
  logic csbFall, csbRise, sclkRise, sclkFall;
  logic [CW-1:0] bitMod;
  logic edgeSeen;
  logic [GW-1:0] gapTimer;
  logic tooSoon;
  logic errFlag;
  logic countOk, badNow, acceptNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csbPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csbPrev  <= csbS;
      sclkPrev <= sclkS;
    end
  end

  assign csbFall  = csbPrev & ~csbS;
  assign csbRise  = ~csbPrev & csbS;
  assign sclkRise = sclkS & ~sclkPrev & ~csbS & ~csbPrev;
  assign sclkFall = ~sclkS & sclkPrev & ~csbS & ~csbPrev;

  // Count modulo the frame length; a nonzero multiple shows as zero plus seen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitMod   <= '0;
      edgeSeen <= 1'b0;
    end else if (csbFall) begin
      bitMod   <= '0;
      edgeSeen <= 1'b0;
    end else if (sclkRise) begin
      bitMod   <= (bitMod == LAST_BIT) ? '0 : bitMod + 1'b1;
      edgeSeen <= 1'b1;
    end
  end

  // Idle timer restarts on each frame end and saturates at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapTimer <= GAP_MAX;
      tooSoon  <= 1'b0;
    end else begin
      if (csbRise) gapTimer <= '0;
      else if (gapTimer != GAP_MAX) gapTimer <= gapTimer + 1'b1;
      if (csbFall) tooSoon <= (gapTimer < GAP_MAX);
    end
  end

  assign countOk   = edgeSeen && (bitMod == '0);
  assign acceptNow = csbRise && countOk && crcOk;
  assign badNow    = csbRise && (!countOk || !crcOk || tooSoon);
  assign errNext   = badNow || (errFlag && !(acceptNow && clearHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= errNext;
  end

  always_comb begin
    st.startFrame  = csbFall;
    st.takeBit     = sclkRise;
    st.nextBit     = sclkFall;
    st.closeFrame  = csbRise;
    st.acceptFrame = acceptNow;
  end

  assign regValid = acceptNow;
  assign intN     = ~errFlag;
endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  strobe_t           st,
  input  logic              errNext,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              crcOk,
  output logic              clearHit,
  output logic              miso
);
  localparam int PAD_W = HEAD_W - 1;

  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] replyWord;
  logic [BODY_W-1:0]     replyBody;
  logic                  active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (st.takeBit) rxShift <= {rxShift[FRAME_BITS-2:0], mosiS};
  end

  assign regWrite = rxShift[FRAME_BITS-1];
  assign regAddr  = rxShift[FRAME_BITS-2 -: ADDR_W];
  assign regWdata = rxShift[CRC_W +: DATA_W];
  assign crcOk    = (crcCalc(rxShift[FRAME_BITS-1:CRC_W]) == rxShift[CRC_W-1:0]);
  assign clearHit = regWrite && (regAddr == CLEAR_ADDR) && regWdata[0];

  assign replyBody = {errNext, {PAD_W{1'b0}}, regRdata};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) replyWord <= REJECT_REPLY;
    else if (st.closeFrame)
      replyWord <= st.acceptFrame ? {replyBody, crcCalc(replyBody)} : REJECT_REPLY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      active  <= 1'b0;
    end else if (st.startFrame) begin
      txShift <= replyWord;
      active  <= 1'b1;
    end else if (st.closeFrame) begin
      active  <= 1'b0;
    end else if (st.nextBit) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign miso = active & txShift[FRAME_BITS-1];
endmodule

// File: rtl/spi_frame_guard.sv
module spi_frame_guard
  import sfg_pkg::*;
#(
  parameter int GAP_CYCLES = 4750,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csbN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              intN,
  output logic              regValid,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  logic [2:0] pinSync;
  strobe_t    strobes;
  logic       crcOk, clearHit, errNext;

  sfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rstN(rstN), .din({csbN, sclk, mosi}), .dout(pinSync)
  );

  sfg_ctrl #(.GAP_CYCLES(GAP_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csbS(pinSync[2]), .sclkS(pinSync[1]),
    .crcOk(crcOk), .clearHit(clearHit), .st(strobes), .errNext(errNext),
    .regValid(regValid), .intN(intN)
  );

  sfg_datapath dp_i (
    .clk(clk), .rstN(rstN), .mosiS(pinSync[0]), .st(strobes), .errNext(errNext),
    .regRdata(regRdata), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .crcOk(crcOk), .clearHit(clearHit), .miso(miso)
  );
endmodule

// File: rtl/spi_frame_guard_chk.sv
module spi_frame_guard_chk (
  input logic clk,
  input logic rstN,
  input logic csbN,
  input logic miso,
  input logic intN,
  input logic regValid
);
  // R6: a register request lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regValid |=> !regValid);

  // R6: a request only follows chip select going high
  a_r6_after_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> ($past(csbN) && $past(csbN, 2)));

  // R9: the fault holds unless an accepted frame is presented
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !regValid) |=> !intN);

  // R9: the fault only appears after a frame has ended
  a_r9_fault_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> (csbN && $past(csbN)));

  // R11: data out is idle while chip select stays high
  a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csbN && $past(csbN) && $past(csbN, 2) && $past(csbN, 3) && $past(csbN, 4)) |-> !miso);
endmodule

bind spi_frame_guard spi_frame_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .csbN(csbN), .miso(miso), .intN(intN), .regValid(regValid)
);

// File: tb/spi_frame_guard_tb_top.sv
module spi_frame_guard_tb_top;
  localparam int GAP  = 300;
  localparam int HALF = 10;
  localparam int LONG_GAP  = 340;
  localparam int SHORT_GAP = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csbN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, intN, regValid, regWrite;
  logic [6:0] regAddr;
  logic [7:0] regWdata, regRdata;

  always #2 clk = ~clk;

  spi_frame_guard #(.GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .csbN(csbN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .intN(intN), .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  logic [7:0] regFile [128];
  assign regRdata = regFile[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) regFile[i] <= 8'h00;
    end else if (regValid && regWrite) begin
      regFile[regAddr] <= regWdata;
    end
  end

  int pulses = 0;
  always @(posedge clk) if (regValid) pulses++;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  modelMem [128];
  logic        modelErr = 1'b0;
  logic [23:0] modelReply = 24'h3C0000;
  bit          prevRejected = 1;
  bit          firstFrame = 1;
  int          lastGap = 0;

  function automatic logic [7:0] crcRef(input logic [15:0] d);
    logic [7:0] c = 8'hFF;
    for (int i = 15; i >= 0; i--) begin
      logic top = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (top) c = c ^ 8'h2F;
    end
    return c;
  endfunction

  function automatic logic [23:0] mk(input bit wr, input logic [6:0] a, input logic [7:0] d);
    return {wr, a, d, crcRef({wr, a, d})};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runFrame(input logic [23:0] word, input int nbits, input int gapAfter,
                          input string req);
    logic [23:0] got = '0;
    bit countOk, crcOk, tooSoon, bad, accept, clr;
    logic [15:0] body;
    logic [7:0] old;
    pulses = 0;
    csbN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23 - (i % 24)];
      repeat (HALF) @(negedge clk);
      if (i < 24) got[23 - i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csbN = 1'b1;
    repeat (12) @(negedge clk);

    if (nbits >= 24)
      check(prevRejected ? "R8" : "R7", "reply word", 32'(got), 32'(modelReply));

    countOk = (nbits > 0) && (nbits % 24 == 0);
    crcOk   = (crcRef(word[23:8]) == word[7:0]);
    tooSoon = !firstFrame && (lastGap < GAP);
    bad     = !countOk || !crcOk || tooSoon;
    accept  = countOk && crcOk;
    if (accept) begin
      old = modelMem[word[22:16]];
      clr = word[23] && (word[22:16] == 7'h7F) && word[8];
      modelErr = bad || (modelErr && !clr);
      if (word[23]) modelMem[word[22:16]] = word[15:8];
      body = {modelErr, 7'b0, old};
      modelReply = {body, crcRef(body)};
    end else begin
      modelErr = modelErr || bad;
      modelReply = 24'h3C0000;
    end
    prevRejected = !accept;

    check(req, "regValid pulses", 32'(pulses), accept ? 32'd1 : 32'd0);
    check("R9", "intN after frame", 32'(intN), 32'(!modelErr));
    check("R11", "miso idle", 32'(miso), 32'd0);

    repeat (gapAfter - 12) @(negedge clk);
    lastGap = gapAfter;
    firstFrame = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    for (int i = 0; i < 128; i++) modelMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R11", "reset intN", 32'(intN), 32'd1);
    check("R11", "reset miso", 32'(miso), 32'd0);
    check("R11", "reset regValid", 32'(regValid), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R6 R7: write then read back a spread of addresses
    for (int a = 0; a < 127; a += 9) runFrame(mk(1, 7'(a), 8'(a * 3 + 1)), 24, LONG_GAP, "R6");
    for (int a = 0; a < 127; a += 9) runFrame(mk(0, 7'(a), 8'h00), 24, LONG_GAP, "R1");

    // R2: bad edge counts rejected, then a double-length frame accepted
    runFrame(mk(1, 7'd3, 8'hAA), 23, LONG_GAP, "R2");
    runFrame(mk(0, 7'd3, 8'h00), 24, LONG_GAP, "R2");
    runFrame(mk(1, 7'd3, 8'hAB), 25, LONG_GAP, "R2");
    runFrame(mk(0, 7'd3, 8'h00), 24, LONG_GAP, "R2");
    runFrame(mk(1, 7'd3, 8'hAC), 0, LONG_GAP, "R2");
    check("R9", "fault after count errors", 32'(intN), 32'd0);
    // R10: clear with bit 0 low does nothing
    runFrame(mk(1, 7'h7F, 8'hFE), 24, LONG_GAP, "R10");
    check("R10", "clear bit low keeps fault", 32'(intN), 32'd0);
    runFrame(mk(1, 7'h7F, 8'h01), 24, LONG_GAP, "R10");
    check("R10", "fault cleared", 32'(intN), 32'd1);
    runFrame(mk(1, 7'd4, 8'h5E), 48, LONG_GAP, "R2");
    runFrame(mk(0, 7'd4, 8'h00), 24, LONG_GAP, "R2");

    // R3 R5: every single-bit corruption is rejected and writes nothing
    for (int b = 0; b < 24; b++) begin
      w = mk(1, 7'd5, 8'hC3);
      w[b] = ~w[b];
      runFrame(w, 24, LONG_GAP, "R3");
      runFrame(mk(1, 7'h7F, 8'h01), 24, LONG_GAP, "R10");
    end
    runFrame(mk(0, 7'd5, 8'h00), 24, LONG_GAP, "R5");
    check("R5", "register 5 untouched", 32'(regFile[5]), 32'(modelMem[5]));

    // R4: too-early frame is accepted but flags the fault
    runFrame(mk(0, 7'd9, 8'h00), 24, SHORT_GAP, "R6");
    runFrame(mk(1, 7'd6, 8'h77), 24, LONG_GAP, "R4");
    check("R4", "gap fault raised", 32'(intN), 32'd0);
    check("R4", "early write landed", 32'(regFile[6]), 32'h77);
    // R10: a clear inside a too-early frame does not clear
    runFrame(mk(0, 7'd6, 8'h00), 24, SHORT_GAP, "R6");
    runFrame(mk(1, 7'h7F, 8'h01), 24, LONG_GAP, "R10");
    check("R10", "early clear keeps fault", 32'(intN), 32'd0);
    runFrame(mk(1, 7'h7F, 8'h01), 24, LONG_GAP, "R10");
    check("R10", "clear after idle", 32'(intN), 32'd1);
    runFrame(mk(0, 7'd6, 8'h00), 24, LONG_GAP, "R7");

    for (int a = 0; a < 127; a += 9)
      check("R6", "register file vs model", 32'(regFile[a]), 32'(modelMem[a]));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule